// File: doc/BRIEF.md
# Shared Memory Two-Port Arbiter

This block shares one single-port RAM between two requesters. The host port can read or write. The network receive port only writes. Each port presents a level request together with an address, write data and, for the host, a direction bit. The arbiter latches the winning request and drives the RAM for a fixed number of clocks. The number depends on the access type. When that cycle ends, the arbiter pulses a completion strobe to the port that owned it. For a host read, the read data is presented alongside the strobe.

Network writes normally win. A waiting host still gets the memory after at most a parameterised number of network accesses, counted since the last host access. A requester must drop its request in the cycle where its completion strobe is high. If the request is still high there, it is taken as a new access.

Top module: `shmem_arb`

## Requirements
- R1: During and just after reset, `mem_en`, `host_ack` and `net_done` are low.
- R2: A host write (`host_we`=1) drives `mem_en` and `mem_we` high for exactly HW_CYC consecutive cycles (default 9).
- R3: A host read (`host_we`=0) drives `mem_en` high with `mem_we` low for exactly HR_CYC cycles (default 5). The RAM word at `host_addr` appears on `host_rdata` while `host_ack` is high.
- R4: A network write drives `mem_en` and `mem_we` high for exactly NW_CYC cycles (default 5).
- R5: When both ports request in the same idle cycle and no host is owed a turn, the network access is granted first.
- R6: After the most recent host grant (or reset), at most NET_BURST network grants (default 2) are made while a host request waits. Under steady contention the grant order is net, net, host, repeating.
- R7: `host_ack` or `net_done` is a single-cycle pulse. It is high in the cycle right after the last `mem_en` cycle of that port's access.
- R8: Only one access uses the RAM at a time. `mem_addr`, `mem_we` and `mem_wdata` stay stable through an access, and `mem_en` is low while a completion pulse is high.
- R9: While an access is active, no other request is accepted. A request still high during its own completion pulse starts a new access one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request (level) |
| host_we | input | 1 | Host direction, 1 = write |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_ack | output | 1 | Host access complete pulse |
| host_rdata | output | DW | Host read data, valid with host_ack |
| net_req | input | 1 | Network write request (level) |
| net_addr | input | AW | Network word address |
| net_wdata | input | DW | Network write data |
| net_done | output | 1 | Network write complete pulse |
| mem_en | output | 1 | RAM cycle active |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data (combinational from mem_addr) |

## Verification
A request raised before an edge makes `mem_en` high in the very next cycle. It stays high for the access length L, and the completion pulse falls in cycle L+1, with read data valid there. The next grant can start in cycle L+2. The bench raises requests just after a falling edge and then samples at each falling edge, numbering those samples from one. It checks that `mem_en` is high in samples 1..L, that the pulse is in sample L+1 and gone at L+2, and that a held request restarts at L+2. Grant order under contention is taken from each rising `mem_en` seen at a falling edge.

// File: rtl/shmem_arb.sv
module shmem_arb #(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int HW_CYC    = 9,
  parameter int HR_CYC    = 5,
  parameter int NW_CYC    = 5,
  parameter int NET_BURST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  input  logic          net_req,
  input  logic [AW-1:0] net_addr,
  input  logic [DW-1:0] net_wdata,
  output logic          net_done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int MAXC = (HW_CYC > HR_CYC) ? ((HW_CYC > NW_CYC) ? HW_CYC : NW_CYC)
                                          : ((HR_CYC > NW_CYC) ? HR_CYC : NW_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int RW = $clog2(NET_BURST + 1);

  logic          busy, own_host;
  logic [CW-1:0] cnt;
  logic [RW-1:0] run;

  wire pick_host = host_req && (!net_req || run >= RW'(NET_BURST));
  wire pick_net  = net_req && !pick_host;

  assign mem_en = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      own_host   <= 1'b0;
      cnt        <= '0;
      run        <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      host_ack   <= 1'b0;
      net_done   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= 1'b0;
      net_done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (own_host) begin
            host_ack <= 1'b1;
            if (!mem_we) host_rdata <= mem_rdata;
          end else begin
            net_done <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (pick_host) begin
        busy      <= 1'b1;
        own_host  <= 1'b1;
        mem_we    <= host_we;
        mem_addr  <= host_addr;
        mem_wdata <= host_wdata;
        cnt       <= host_we ? CW'(HW_CYC - 1) : CW'(HR_CYC - 1);
        run       <= '0;
      end else if (pick_net) begin
        busy      <= 1'b1;
        own_host  <= 1'b0;
        mem_we    <= 1'b1;
        mem_addr  <= net_addr;
        mem_wdata <= net_wdata;
        cnt       <= CW'(NW_CYC - 1);
        if (run < RW'(NET_BURST)) run <= run + 1'b1;
      end
    end
  end

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_done |=> !net_done);

  // R8
  idle_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack || net_done) |-> !mem_en);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_ack, net_done}));

  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(NET_BURST));
endmodule

// File: tb/shmem_arb_tb.sv
module shmem_arb_tb;
  localparam int AW = 4, DW = 16;
  localparam int LHW = 9, LHR = 5, LNW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0, net_req = 1'b0;
  logic [AW-1:0] host_addr = '0, net_addr = '0;
  logic [DW-1:0] host_wdata = '0, net_wdata = '0;
  logic host_ack, net_done, mem_en, mem_we;
  logic [DW-1:0] host_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] ram [0:(1<<AW)-1];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) ram[i] <= DW'(i * 16'h0101);
    end else if (mem_en && mem_we) begin
      ram[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = ram[mem_addr];

  shmem_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .net_req(net_req), .net_addr(net_addr), .net_wdata(net_wdata), .net_done(net_done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // kind: 0 host write, 1 host read, 2 net write ; {kind, addr, data}
  localparam logic [21:0] VEC [0:8] = '{
    {2'd0, 4'h3, 16'hA5A5}, {2'd1, 4'h3, 16'hA5A5},
    {2'd2, 4'h5, 16'h1234}, {2'd1, 4'h5, 16'h1234},
    {2'd1, 4'h7, 16'h0707}, {2'd2, 4'h3, 16'hBEEF},
    {2'd1, 4'h3, 16'hBEEF}, {2'd0, 4'hF, 16'h0F0F},
    {2'd1, 4'hF, 16'h0F0F}
  };
  localparam bit EXP_SEQ [0:8] = '{0, 0, 1, 0, 0, 1, 0, 0, 1};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int len, en_cnt, done_at;
    bit bad_we, bad_addr, done_en;
    logic [DW-1:0] rd;
    len = (k == 2'd0) ? LHW : (k == 2'd1) ? LHR : LNW;
    en_cnt = 0; done_at = 0; bad_we = 0; bad_addr = 0; done_en = 0; rd = '0;
    @(negedge clk);
    if (k == 2'd2) begin
      net_req = 1'b1; net_addr = a; net_wdata = d;
    end else begin
      host_req = 1'b1; host_we = (k == 2'd0); host_addr = a; host_wdata = d;
    end
    for (int i = 1; i <= 30 && done_at == 0; i++) begin
      @(negedge clk);
      if (mem_en) begin
        en_cnt++;
        if (mem_we != (k != 2'd1)) bad_we = 1;
        if (mem_addr != a) bad_addr = 1;
      end
      if ((k == 2'd2) ? net_done : host_ack) begin
        done_at = i; done_en = mem_en; rd = host_rdata;
        host_req = 1'b0; net_req = 1'b0;
      end
    end
    if (k == 2'd0) chk(en_cnt == len, "R2 host write length", en_cnt, len);
    else if (k == 2'd1) chk(en_cnt == len, "R3 host read length", en_cnt, len);
    else chk(en_cnt == len, "R4 net write length", en_cnt, len);
    chk(done_at == len + 1, "R7 completion cycle", done_at, len + 1);
    chk(!done_en && !bad_addr && !bad_we, "R8 idle/stable access", {bad_addr, bad_we, done_en}, 0);
    if (k == 2'd1) chk(rd == d, "R3 read data", rd, d);
    @(negedge clk);
    chk(!host_ack && !net_done, "R7 single-cycle pulse", {host_ack, net_done}, 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nseq, rise1, fall1, rise2;
    bit prev;
    repeat (3) @(negedge clk);
    chk(!mem_en && !host_ack && !net_done, "R1 in reset", {mem_en, host_ack, net_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_en && !host_ack && !net_done, "R1 after reset", {mem_en, host_ack, net_done}, 0);

    for (int v = 0; v < 9; v++) run_one(VEC[v][21:20], VEC[v][19:16], VEC[v][15:0]);

    // R9: host read held through its ack restarts one cycle after the pulse
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 4'h2;
    rise1 = 0; fall1 = 0; rise2 = 0; prev = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (mem_en && !prev && rise1 == 0) rise1 = i;
      else if (mem_en && !prev && rise2 == 0) rise2 = i;
      if (!mem_en && prev && fall1 == 0) fall1 = i;
      if (host_ack && rise2 != 0) host_req = 1'b0;
      prev = mem_en;
    end
    host_req = 1'b0;
    chk(rise1 == 1, "R9 first start", rise1, 1);
    chk(rise2 == LHR + 2, "R9 held request restart", rise2, LHR + 2);
    repeat (3) @(negedge clk);

    // R5 / R6: sustained contention, host addr 1, net addr 2
    host_we = 1'b1; host_addr = 4'h1; host_wdata = 16'h1111;
    net_addr = 4'h2; net_wdata = 16'h2222;
    host_req = 1'b1; net_req = 1'b1;
    nseq = 0; prev = 0;
    for (int i = 0; i < 300 && nseq < 9; i++) begin
      @(negedge clk);
      if (mem_en && !prev) begin
        if (nseq == 0)
          chk(mem_addr == 4'h2, "R5 net first on tie", mem_addr, 2);
        chk((mem_addr == 4'h1) == EXP_SEQ[nseq], "R6 grant order", mem_addr, EXP_SEQ[nseq] ? 1 : 2);
        nseq++;
      end
      prev = mem_en;
      if (host_ack) host_req = 1'b0;
      else host_req = 1'b1;
    end
    chk(nseq == 9, "R6 grant count", nseq, 9);
    host_req = 1'b0; net_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(!mem_en, "R8 idle after requests drop", mem_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule